// File: doc/BRIEF.md
# System Timer with Periodic Alarm

This peripheral keeps a free-running tick counter for a small microcontroller. A prescaler divides the CPU clock so that the counter advances once every `PRESCALE` clock cycles. A separate period counter raises the target-0 alarm every `ALARM_TICKS` timer ticks. With the default parameters the counter runs at one tenth of a 160 MHz CPU clock, and the alarm fires once per millisecond.

Software talks to the block over a byte-wide register bus:

- **Writes** take effect on the clock edge and touch one 8-bit lane of the addressed 32-bit word.
- **Reads** are combinational from the current address.

Interrupt state is kept at several views:

- an enable mask;
- a sticky raw status;
- a write-one-to-clear port;
- a masked view that combines the raw status with the enable mask.

The interrupt line is the OR of the masked bits. The line also carries the fixed CPU interrupt number that it is routed to. To read the counter without tearing, software requests a snapshot. It polls a valid flag and then reads the low and high halves of the latched value.

Top module: `sys_timer`

## Requirements
- R1: After reset the following all read zero: every register byte, the raw status, the enable mask, the snapshot value and the valid flag. The interrupt line is low.
- R2: The counter starts at zero when reset is released. It increments once every PRESCALE clock edges, so after k edges out of reset it holds floor(k/PRESCALE).
- R3: Writing a byte with bit 6 set to offset 0x17 requests a snapshot. That offset and bit are bit 30 of word 0x14. Valid is read as bit 5 of byte 0x17 (bit 29 of the word).
  - Valid reads 0 in the cycle after the request edge.
  - Valid reads 1 from the edge after that. That same edge latches the counter value it held on entry.
  - The latched value is readable as little-endian bytes at 0x54..0x57 (bits 31:0) and 0x58..0x5B (the upper bits).
  - The value holds until the next request.
  - A write to 0x17 with bit 6 clear changes nothing.
- R4: The target-0 alarm fires on every ALARM_TICKS-th tick. Each firing sets raw status bit 0 (byte 0x08, bit 0) on that edge. Raw status bits 1 and 2 stand for targets 1 and 2 and have no source.
- R5: Byte 0x10 reads the bitwise AND of raw status (0x08) and the enable mask (0x04, bits 2:0).
- R6: Writing byte 0x0C clears each raw status bit whose data bit is 1 and leaves the bits written as 0 unchanged. Byte 0x0C reads as zero. An alarm firing on the same edge as a clear wins.
- R7: A byte write changes only its own 8-bit lane of the addressed word. A write to byte 0x05 leaves the enable mask in byte 0x04 unchanged.
- R8: Offsets that are not mapped read zero, and writes to them have no effect.
- R9: `irq_o` is high exactly when some masked status bit is set, and stays high until that raw bit is cleared or its enable is removed. `irq_id_o` carries the CPU interrupt number IRQ_ID (default 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address within the register window |
| bus_we | input | 1 | Byte write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data for the addressed byte lane |
| bus_rdata | output | 8 | Combinational read data for the addressed byte |
| irq_o | output | 1 | Level interrupt request, OR of masked status |
| irq_id_o | output | 5 | CPU interrupt number this line is routed to |

## Verification
The bench reads raw status one cycle before and one cycle after the alarm edge. A design whose period is off by one tick fails on one side of that window.

The two snapshots are checked against values derived from the edge count since reset, and the valid flag is sampled in the cycle straight after the request. A prescaler off by one cycle, a capture taken one edge too early, or a valid flag that never drops would each show a wrong value there.

Clear writes with only zero bits in the target-0 position must leave the raw bit set. Byte-lane writes to the enable word's upper bytes must leave the mask intact. With the raw bit held, toggling the enable bit must move both the masked view and the interrupt line. This catches a line that is driven from raw status alone.

// File: rtl/sys_timer_pkg.sv
package sys_timer_pkg;

    typedef logic [31:0] word_t;

    // Word indices (byte offset / 4) of the register window
    typedef enum logic [5:0] {
        W_ENABLE = 6'h01,
        W_RAW    = 6'h02,
        W_CLEAR  = 6'h03,
        W_MASKED = 6'h04,
        W_SNAP   = 6'h05,
        W_VAL_LO = 6'h15,
        W_VAL_HI = 6'h16
    } word_idx_e;

    localparam int SNAP_REQ_BIT   = 30;
    localparam int SNAP_VALID_BIT = 29;

endpackage

// File: rtl/st_tick_gen.sv
module st_tick_gen #(
    parameter int PRESCALE = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    typedef struct packed {
        logic [PW-1:0] pre;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_o) st_d.pre = '0;
        else        st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = (st_q.pre == PW'(PRESCALE - 1));

    generate
        if (PRESCALE > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/st_counter.sv
module st_counter #(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             snap_req_i,
    output logic [CNT_W-1:0] snap_val_o,
    output logic             snap_ok_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] snap;
        logic             pend;
        logic             valid;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) st_d.cnt = st_q.cnt + 1'b1;
        if (snap_req_i) begin
            st_d.pend  = 1'b1;
            st_d.valid = 1'b0;
        end else if (st_q.pend) begin
            st_d.pend  = 1'b0;
            st_d.snap  = st_q.cnt;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap_val_o = st_q.snap;
    assign snap_ok_o  = st_q.valid;

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> st_q.cnt == $past(st_q.cnt) + 1'b1);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.cnt));

    // R3
    snap_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req_i |=> !snap_ok_o);

    // R3
    snap_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !snap_req_i) |=> (snap_ok_o && snap_val_o == $past(st_q.cnt)));

endmodule

// File: rtl/st_alarm.sv
module st_alarm #(
    parameter int ALARM_TICKS = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output logic fire_o
);
    localparam int AW = (ALARM_TICKS > 1) ? $clog2(ALARM_TICKS) : 1;

    typedef struct packed {
        logic [AW-1:0] ctr;
    } state_t;

    state_t st_d, st_q;

    assign fire_o = tick_i && (st_q.ctr == AW'(ALARM_TICKS - 1));

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (fire_o) st_d.ctr = '0;
            else        st_d.ctr = st_q.ctr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    fire_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> tick_i);

endmodule

// File: rtl/sys_timer.sv
module sys_timer #(
    parameter int PRESCALE    = 10,
    parameter int CNT_W       = 52,
    parameter int ALARM_TICKS = 16000,
    parameter int NUM_TGT     = 3,
    parameter int IRQ_ID      = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_o,
    output logic [4:0] irq_id_o
);
    import sys_timer_pkg::*;

    localparam int HI_W = CNT_W - 32;

    typedef struct packed {
        logic [NUM_TGT-1:0] ena;
        logic [NUM_TGT-1:0] raw;
    } state_t;

    state_t st_d, st_q;

    logic             tick, fire;
    logic             snap_req, snap_ok;
    logic [CNT_W-1:0] snap_val;
    logic [5:0]       word_sel;
    logic [1:0]       lane_sel;
    logic             ena_wr, clr_wr;
    logic [NUM_TGT-1:0] clr_mask;
    word_t            rd_word;
    logic [63:0]      snap64;

    assign word_sel = bus_addr[7:2];
    assign lane_sel = bus_addr[1:0];

    assign ena_wr   = bus_we && (word_sel == W_ENABLE) && (lane_sel == 2'd0);
    assign clr_wr   = bus_we && (word_sel == W_CLEAR)  && (lane_sel == 2'd0);
    assign clr_mask = clr_wr ? bus_wdata[NUM_TGT-1:0] : '0;
    assign snap_req = bus_we && (word_sel == W_SNAP) && (lane_sel == 2'd3)
                      && bus_wdata[SNAP_REQ_BIT - 24];

    st_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(tick)
    );

    st_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .snap_req_i(snap_req),
        .snap_val_o(snap_val),
        .snap_ok_o (snap_ok)
    );

    st_alarm #(.ALARM_TICKS(ALARM_TICKS)) u_alarm (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .fire_o(fire)
    );

    always_comb begin
        st_d = st_q;
        if (ena_wr) st_d.ena = bus_wdata[NUM_TGT-1:0];
        st_d.raw = st_q.raw & ~clr_mask;
        if (fire) st_d.raw[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign snap64 = 64'(snap_val);

    always_comb begin
        rd_word = '0;
        case (word_sel)
            W_ENABLE: rd_word = 32'(st_q.ena);
            W_RAW:    rd_word = 32'(st_q.raw);
            W_MASKED: rd_word = 32'(st_q.raw & st_q.ena);
            W_SNAP:   rd_word[SNAP_VALID_BIT] = snap_ok;
            W_VAL_LO: rd_word = snap64[31:0];
            W_VAL_HI: rd_word = 32'(snap64[32 +: HI_W]);
            default:  rd_word = '0;
        endcase
    end

    assign bus_rdata = rd_word[8*lane_sel +: 8];
    assign irq_o     = |(st_q.raw & st_q.ena);
    assign irq_id_o  = 5'(IRQ_ID);

    // R4
    alarm_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> st_q.raw[0]);

    // R6
    clear_drops_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask[0] && !fire) |=> !st_q.raw[0]);

    // R6
    clear_keeps_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !bus_wdata[0] && st_q.raw[0]) |=> st_q.raw[0]);

    // R7
    enable_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_wr |=> $stable(st_q.ena));

endmodule

// File: tb/test_sys_timer.sv
module test_sys_timer;

    localparam int PRESCALE = 10;
    localparam int TICKS    = 30;
    localparam int PERIOD   = PRESCALE * TICKS;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_o;
    logic [4:0] irq_id_o;

    always #2 clk = ~clk;

    sys_timer #(
        .PRESCALE(PRESCALE), .CNT_W(52), .ALARM_TICKS(TICKS), .NUM_TGT(3), .IRQ_ID(1)
    ) i_sys_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .irq_id_o(irq_id_o)
    );

    int ec;
    always @(posedge clk) begin
        if (!rst_n) ec <= 0;
        else        ec <= ec + 1;
    end

    typedef struct {
        int         kind;
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  smp;
    int    nvec  = 0;
    int    nfail = 0;
    bit    done  = 0;

    initial begin
        forever begin
            @(smp);
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] got;
                it = q.pop_front();
                case (it.kind)
                    0:       got = bus_rdata;
                    1:       got = {7'b0, irq_o};
                    default: got = {3'b0, irq_id_o};
                endcase
                nvec++;
                if (got !== it.exp) begin
                    nfail++;
                    $display("FAIL %s kind=%0d addr=%02h got=%02h exp=%02h",
                             it.tag, it.kind, it.addr, got, it.exp);
                end
            end
        end
    end

    task automatic push(input int kind, input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = kind; it.addr = a; it.exp = e; it.tag = tag;
        #1;
        q.push_back(it);
        ->smp;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        push(0, a, e, tag);
    endtask

    task automatic rd32(input logic [7:0] base, input logic [31:0] e, input string tag);
        for (int i = 0; i < 4; i++) rd(base + 8'(i), e[8*i +: 8], tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, output int e_at);
        @(negedge clk);
        e_at = ec;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        @(negedge clk);
        push(1, 8'h00, {7'b0, e}, tag);
    endtask

    task automatic run_to(input int target);
        while (ec < target) @(negedge clk);
    endtask

    task automatic finish_run();
        #1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int e0, e1, dummy;
        logic [31:0] s1;
        rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'h04, 8'h00, "R1 enable");
        rd(8'h08, 8'h00, "R1 raw");
        rd(8'h10, 8'h00, "R1 masked");
        rd(8'h17, 8'h00, "R1 valid");
        rd32(8'h54, 32'h0, "R1 snap lo");
        rd32(8'h58, 32'h0, "R1 snap hi");
        chk_irq(1'b0, "R1 irq");
        @(negedge clk); push(2, 8'h00, 8'h01, "R9 irq id");

        // R8: unmapped offsets
        rd(8'h00, 8'h00, "R8 off00");
        wr(8'h20, 8'hFF, dummy);
        rd(8'h20, 8'h00, "R8 off20");
        rd(8'hFC, 8'h00, "R8 offFC");

        // R7: byte lanes of enable word
        wr(8'h04, 8'h05, dummy);
        rd(8'h04, 8'h05, "R7 enable lane0");
        wr(8'h05, 8'hFF, dummy);
        rd(8'h04, 8'h05, "R7 enable after lane1 write");
        rd(8'h05, 8'h00, "R7 lane1 reads zero");
        rd(8'h10, 8'h00, "R5 masked with raw clear");

        // R3: snapshot handshake
        @(negedge clk);
        e0 = ec;
        bus_addr = 8'h17; bus_wdata = 8'h40; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        push(0, 8'h17, 8'h00, "R3 valid low after request");
        rd(8'h17, 8'h20, "R3 valid high");
        rd32(8'h54, 32'((e0 + 1) / PRESCALE), "R3 snap lo first");
        rd32(8'h58, 32'h0, "R3 snap hi");

        // R2: second snapshot after a gap
        repeat (37) @(negedge clk);
        wr(8'h17, 8'h40, e1);
        s1 = 32'((e1 + 1) / PRESCALE);
        rd32(8'h54, s1, "R2 snap lo second");
        wr(8'h17, 8'h00, dummy);
        rd(8'h17, 8'h20, "R3 no request keeps valid");
        repeat (25) @(negedge clk);
        rd32(8'h54, s1, "R3 snap holds");

        // R4: first alarm edge window
        run_to(PERIOD - 2);
        rd(8'h08, 8'h00, "R4 raw before alarm");
        rd(8'h08, 8'h01, "R4 raw at alarm");
        chk_irq(1'b1, "R9 irq on alarm");
        rd(8'h10, 8'h01, "R5 masked on alarm");

        // R6: clear semantics
        wr(8'h0C, 8'h06, dummy);
        rd(8'h08, 8'h01, "R6 zero bits keep raw");
        rd(8'h0C, 8'h00, "R6 clear reads zero");
        wr(8'h04, 8'h04, dummy);
        rd(8'h10, 8'h00, "R5 masked with enable off");
        chk_irq(1'b0, "R9 irq with enable off");
        wr(8'h04, 8'h01, dummy);
        chk_irq(1'b1, "R9 irq held while raw set");
        wr(8'h0C, 8'h01, dummy);
        rd(8'h08, 8'h00, "R6 one clears raw");
        chk_irq(1'b0, "R9 irq drops after clear");

        // R4: second period
        run_to(2 * PERIOD - 2);
        rd(8'h08, 8'h00, "R4 raw before second alarm");
        rd(8'h08, 8'h01, "R4 raw at second alarm");
        chk_irq(1'b1, "R9 irq second alarm");

        done = 1;
        finish_run();
    end

endmodule